// File: doc/BRIEF.md
# Interrupt Pending-Active State Controller

This block keeps a two-bit status record for each of several interrupt sources and picks the source the processor should service next. Each source is configured as either level-sensitive or pulse-type, and each has a 3-bit urgency value. The processor tells the block when it starts a handler (`enter_strb`) and when it finishes one (`return_strb`). Only one handler runs at a time, and handlers do not nest.

The status of a source is a pair {active, pending}. The four values are 00 inactive, 01 pending, 10 active and 11 active-and-pending.

- A pulse-type source is edge-detected against a registered copy of its line. Any rising edge sets the pending bit, including an edge that arrives while that source's handler runs.
- A level-sensitive source becomes pending while its line is high and it is not active. When its handler returns, the line is sampled again.
- Events that arrive while the pending bit is already set merge into that one bit.

The request output is registered. `req_valid` rises one cycle after a pending bit becomes visible, and only while no handler is active. The chosen ID is then frozen until the processor accepts it with `enter_strb`.

Top module: `irq_state_ctrl`

## Requirements
- R1: While `rst_n` is low, every source is inactive (`src_pend` and `src_act` all zero), `req_valid` is 0 and `sel_id` is 0.
- R2: A pulse-type source (`src_is_pulse[i]`=1) becomes pending at the clock edge where `irq_line[i]` is 1 and was 0 at the previous edge. A level-type source (`src_is_pulse[i]`=0) becomes pending at an edge where its line is 1 and the source is not active.
- R3: At an edge where `enter_strb` and `req_valid` are both 1, source `sel_id` becomes active and its pending bit clears. `req_valid` goes to 0 at the same edge, and at most one source is ever active.
- R4: At an edge where `return_strb` is 1, the active level-type source leaves active. Its pending bit takes the value of its line in that cycle.
- R5: A rising edge on a pulse-type source while it is active makes it active-and-pending (`src_act[i]`=`src_pend[i]`=1). After return it is pending, and `req_valid` reasserts one cycle later.
- R6: A pulse-type source that sees no rising edge during its handler becomes inactive at return.
- R7: Several rising edges before a pulse-type source is serviced leave a single pending bit. After one entry and return, the source is inactive.
- R8: `prio_cfg[i*3 +: 3]` is the urgency of source i, and a lower value is more urgent. When `req_valid` rises, `sel_id` names the pending source with the lowest value; on a tie, the lowest index wins.
- R9: `req_valid` is 1 only when no source is active and source `sel_id` is pending. It is set at the edge after pending sources exist with no handler active. While `req_valid` is 1, `sel_id` and `req_valid` hold until an entry is accepted, even if a more urgent source becomes pending.
- R10: `enter_strb` while `req_valid` is 0 has no effect, and `return_strb` while no source is active has no effect.
- R11: A level-type source keeps its pending bit when its line drops before entry. Its line is ignored while it is active, until return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| irq_line | input | NUM_SRC | Raw interrupt lines, one per source |
| src_is_pulse | input | NUM_SRC | Per-source type: 1 pulse (edge), 0 level |
| prio_cfg | input | NUM_SRC*PRIO_W | Per-source urgency, source i at bits i*PRIO_W +: PRIO_W, lower is more urgent |
| enter_strb | input | 1 | Processor starts the handler for `sel_id` |
| return_strb | input | 1 | Processor finishes the active handler |
| sel_id | output | ID_W | Index of the source offered for service |
| req_valid | output | 1 | A source is offered and no handler is active |
| src_pend | output | NUM_SRC | Per-source pending bit |
| src_act | output | NUM_SRC | Per-source active bit |

## Verification
The bench targets these corner cases:

- A pulse that arrives during a handler. A design that misses it drops the re-entry, or re-enters immediately without the source ever leaving active.
- A level line that is still high, or already low, at return. Getting this wrong either loses a live request or replays a stale one.
- Bursts of pulses before service, which must not produce more than one entry.
- Priority ties, and a more urgent arrival while an ID is already on offer. A flawed arbiter picks the wrong index, or switches `sel_id` under the processor.
- Stray strobes with nothing offered or active, which must leave the state unchanged.

A long random phase then runs against a cycle model built from the requirements.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // {active, pending}
  typedef enum logic [1:0] {
    ST_IDLE     = 2'b00,
    ST_PEND     = 2'b01,
    ST_ACT      = 2'b10,
    ST_ACT_PEND = 2'b11
  } irq_state_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic rise_out
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= line_in;
  end

  assign rise_out = line_in & ~prev_q;
endmodule

// File: rtl/irq_src_state.sv
module irq_src_state
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic pulse_mode,
  input  logic rise_in,
  input  logic enter_hit,
  input  logic ret_hit,
  output logic pend,
  output logic act
);
  irq_state_e st_q, st_d;
  logic nxt_act, nxt_pend;

  assign act  = st_q[1];
  assign pend = st_q[0];

  always_comb begin
    nxt_act  = act;
    nxt_pend = pend;
    if (enter_hit) begin
      nxt_act  = 1'b1;
      nxt_pend = 1'b0;
    end
    if (ret_hit) begin
      nxt_act = 1'b0;
      if (!pulse_mode) nxt_pend = line_in;
    end
    if (pulse_mode) begin
      if (rise_in) nxt_pend = 1'b1;
    end else if (!act && !enter_hit && line_in) begin
      nxt_pend = 1'b1;
    end
    st_d = irq_state_e'({nxt_act, nxt_pend});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // R3
  enter_makes_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_hit |=> act);

  // R4
  level_return_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_hit && !pulse_mode) |=> (!act && (pend == $past(line_in))));

  // R5
  pulse_during_handler_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !ret_hit && pulse_mode && rise_in) |=> (st_q == ST_ACT_PEND));

  // R6
  pulse_quiet_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_hit && pulse_mode && !pend && !rise_in) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 3
) (
  input  logic [NUM_SRC-1:0]        pend_vec,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic [ID_W-1:0]           win_id,
  output logic                      win_any
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    win_id  = '0;
    win_any = 1'b0;
    best    = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_vec[i] && (!win_any || (prio_flat[i*PRIO_W +: PRIO_W] < best))) begin
        win_any = 1'b1;
        best    = prio_flat[i*PRIO_W +: PRIO_W];
        win_id  = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_state_ctrl.sv
module irq_state_ctrl #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  localparam int ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        irq_line,
  input  logic [NUM_SRC-1:0]        src_is_pulse,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_cfg,
  input  logic                      enter_strb,
  input  logic                      return_strb,
  output logic [ID_W-1:0]           sel_id,
  output logic                      req_valid,
  output logic [NUM_SRC-1:0]        src_pend,
  output logic [NUM_SRC-1:0]        src_act
);
  logic [NUM_SRC-1:0] rise_vec, enter_hit, ret_hit;
  logic [ID_W-1:0]    win_id, sel_q, sel_d;
  logic               win_any, valid_q, valid_d, enter_ok, any_act;

  assign enter_ok = enter_strb & valid_q;
  assign any_act  = |src_act;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_edge_det u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_in  (irq_line[g]),
      .rise_out (rise_vec[g])
    );

    assign enter_hit[g] = enter_ok && (sel_q == ID_W'(g));
    assign ret_hit[g]   = return_strb && src_act[g];

    irq_src_state u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_in    (irq_line[g]),
      .pulse_mode (src_is_pulse[g]),
      .rise_in    (rise_vec[g]),
      .enter_hit  (enter_hit[g]),
      .ret_hit    (ret_hit[g]),
      .pend       (src_pend[g]),
      .act        (src_act[g])
    );
  end

  irq_prio_arb #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .ID_W    (ID_W)
  ) u_arb (
    .pend_vec  (src_pend),
    .prio_flat (prio_cfg),
    .win_id    (win_id),
    .win_any   (win_any)
  );

  always_comb begin
    valid_d = valid_q;
    sel_d   = sel_q;
    if (enter_ok) begin
      valid_d = 1'b0;
    end else if (!valid_q && !any_act && win_any) begin
      valid_d = 1'b1;
      sel_d   = win_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      sel_q   <= '0;
    end else begin
      valid_q <= valid_d;
      sel_q   <= sel_d;
    end
  end

  assign req_valid = valid_q;
  assign sel_id    = sel_q;

  // R3
  single_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(src_act) <= 1);

  // R9
  offer_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (!any_act && src_pend[sel_id]));

  // R9
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !enter_strb) |=> (req_valid && $stable(sel_id)));

  // R10
  stray_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_strb && !req_valid && !any_act) |=> !any_act);

  for (genvar p = 0; p < NUM_SRC; p++) begin : g_prio_chk
    // R8
    winner_most_urgent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(req_valid) && $past(src_pend[p]))
        |-> (prio_cfg[sel_id*PRIO_W +: PRIO_W] <= prio_cfg[p*PRIO_W +: PRIO_W]));
  end
endmodule

// File: tb/tb_irq_state_ctrl.sv
module tb_irq_state_ctrl;
  localparam int N = 8;
  localparam int PW = 3;
  localparam int IW = 3;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_line = '0;
  logic [N-1:0]  src_is_pulse = '0;
  logic [N*PW-1:0] prio_cfg = '0;
  logic          enter_strb = 1'b0;
  logic          return_strb = 1'b0;
  logic [IW-1:0] sel_id;
  logic          req_valid;
  logic [N-1:0]  src_pend, src_act;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  logic [N-1:0]  m_pend, m_act, m_prev;
  logic          m_valid;
  logic [IW-1:0] m_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_state_ctrl #(.NUM_SRC(N), .PRIO_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .src_is_pulse(src_is_pulse),
    .prio_cfg(prio_cfg), .enter_strb(enter_strb), .return_strb(return_strb),
    .sel_id(sel_id), .req_valid(req_valid), .src_pend(src_pend), .src_act(src_act)
  );

  function automatic logic [IW-1:0] pick(input logic [N-1:0] p, input logic [N*PW-1:0] pr);
    logic [IW-1:0] w = '0;
    int best = 99;
    for (int i = 0; i < N; i++)
      if (p[i] && int'(pr[i*PW +: PW]) < best) begin
        best = int'(pr[i*PW +: PW]);
        w = IW'(i);
      end
    return w;
  endfunction

  // cycle model built from R2..R11
  always @(posedge clk or negedge rst_n) begin : model
    logic [N-1:0] np, na;
    logic en_ok;
    if (!rst_n) begin
      m_pend <= '0; m_act <= '0; m_prev <= '0; m_valid <= 1'b0; m_sel <= '0;
    end else begin
      en_ok = enter_strb && m_valid;
      np = m_pend;
      na = m_act;
      for (int i = 0; i < N; i++) begin
        if (en_ok && m_sel == IW'(i)) begin na[i] = 1'b1; np[i] = 1'b0; end
        if (return_strb && m_act[i]) begin
          na[i] = 1'b0;
          if (!src_is_pulse[i]) np[i] = irq_line[i];
        end
        if (src_is_pulse[i]) begin
          if (irq_line[i] && !m_prev[i]) np[i] = 1'b1;
        end else if (!m_act[i] && !(en_ok && m_sel == IW'(i)) && irq_line[i]) begin
          np[i] = 1'b1;
        end
      end
      if (en_ok) m_valid <= 1'b0;
      else if (!m_valid && !(|m_act) && (|m_pend)) begin
        m_valid <= 1'b1;
        m_sel <= pick(m_pend, prio_cfg);
      end
      m_pend <= np;
      m_act  <= na;
      m_prev <= irq_line;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_en && !done) begin
      chk("R5 model pend", 32'(src_pend), 32'(m_pend));
      chk("R3 model act", 32'(src_act), 32'(m_act));
      chk("R9 model valid", 32'(req_valid), 32'(m_valid));
      if (m_valid) chk("R8 model sel", 32'(sel_id), 32'(m_sel));
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic enter_once();
    enter_strb = 1'b1; step(); enter_strb = 1'b0;
  endtask

  task automatic return_once();
    return_strb = 1'b1; step(); return_strb = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    src_is_pulse = 8'h0F;
    prio_cfg = {N{3'd4}};
    repeat (3) step();
    // R1
    chk("R1 pend", 32'(src_pend), 0);
    chk("R1 act", 32'(src_act), 0);
    chk("R1 valid", 32'(req_valid), 0);
    chk("R1 sel", 32'(sel_id), 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    step();

    // R2 pulse edge, R3 entry, R5 pulse in handler
    irq_line[1] = 1'b1; step();
    chk("R2 pulse pend", 32'(src_pend), 32'h02);
    step();
    chk("R9 valid", 32'(req_valid), 1);
    chk("R9 sel", 32'(sel_id), 1);
    enter_once();
    chk("R3 act", 32'(src_act), 32'h02);
    chk("R3 pend cleared", 32'(src_pend), 0);
    chk("R3 valid drop", 32'(req_valid), 0);
    irq_line[1] = 1'b0; step();
    irq_line[1] = 1'b1; step();
    chk("R5 act-pend act", 32'(src_act), 32'h02);
    chk("R5 act-pend pend", 32'(src_pend), 32'h02);
    return_once();
    chk("R5 after return act", 32'(src_act), 0);
    chk("R5 after return pend", 32'(src_pend), 32'h02);
    step();
    chk("R5 re-offer", 32'({req_valid, sel_id}), 32'({1'b1, 3'd1}));
    enter_once();
    irq_line[1] = 1'b0;
    return_once();
    chk("R6 quiet return pend", 32'(src_pend), 0);
    chk("R6 quiet return act", 32'(src_act), 0);

    // R7 burst collapse
    for (int k = 0; k < 3; k++) begin
      irq_line[2] = 1'b1; step();
      irq_line[2] = 1'b0; step();
    end
    chk("R7 single pend", 32'(src_pend), 32'h04);
    chk("R7 offered", 32'({req_valid, sel_id}), 32'({1'b1, 3'd2}));
    enter_once();
    return_once();
    chk("R7 extras lost", 32'(src_pend | src_act), 0);
    step();
    chk("R7 no re-offer", 32'(req_valid), 0);

    // R10 stray strobes
    return_once();
    chk("R10 stray return", 32'(src_pend | src_act), 0);
    enter_once();
    chk("R10 stray enter act", 32'(src_act), 0);
    chk("R10 stray enter valid", 32'(req_valid), 0);

    // R4 / R11 level source
    irq_line[5] = 1'b1; step();
    chk("R2 level pend", 32'(src_pend), 32'h20);
    step();
    chk("R9 level offer", 32'({req_valid, sel_id}), 32'({1'b1, 3'd5}));
    enter_once();
    step();
    chk("R11 line ignored while active", 32'(src_pend), 0);
    return_once();
    chk("R4 line high at return pend", 32'(src_pend), 32'h20);
    chk("R4 line high at return act", 32'(src_act), 0);
    step();
    enter_once();
    irq_line[5] = 1'b0;
    return_once();
    chk("R4 line low at return", 32'(src_pend | src_act), 0);

    // R8 priority and tie, R9 hold, R11 latch
    prio_cfg[3*PW +: PW] = 3'd5;
    prio_cfg[4*PW +: PW] = 3'd1;
    prio_cfg[6*PW +: PW] = 3'd1;
    irq_line[3] = 1'b1; irq_line[4] = 1'b1; irq_line[6] = 1'b1; step();
    chk("R8 pend set", 32'(src_pend), 32'h58);
    step();
    chk("R8 tie lowest index", 32'({req_valid, sel_id}), 32'({1'b1, 3'd4}));
    irq_line[4] = 1'b0; irq_line[6] = 1'b0; step();
    chk("R11 level latched", 32'(src_pend), 32'h58);
    prio_cfg[0 +: PW] = 3'd0;
    irq_line[0] = 1'b1; step();
    chk("R9 held sel", 32'({req_valid, sel_id}), 32'({1'b1, 3'd4}));
    chk("R9 urgent pend", 32'(src_pend), 32'h59);
    enter_once(); return_once(); step();
    chk("R8 most urgent", 32'(sel_id), 0);
    enter_once(); return_once(); step();
    chk("R8 next urgent", 32'(sel_id), 6);
    enter_once(); return_once(); step();
    chk("R8 least urgent", 32'(sel_id), 3);
    enter_once(); return_once();
    chk("R8 all serviced", 32'(src_pend | src_act), 0);
    irq_line = '0;
    step();

    // random phase against the model
    void'($urandom(32'd20240611));
    for (int blk = 0; blk < 10; blk++) begin
      src_is_pulse = N'($urandom);
      for (int i = 0; i < N; i++) prio_cfg[i*PW +: PW] = PW'($urandom);
      for (int c = 0; c < 300; c++) begin
        for (int i = 0; i < N; i++)
          if ($urandom_range(7) == 0) irq_line[i] = ~irq_line[i];
        enter_strb  = ($urandom_range(2) == 0);
        return_strb = ($urandom_range(3) == 0);
        step();
      end
    end
    enter_strb = 1'b0;
    return_strb = 1'b0;
    step();
    finish_run();
  end
endmodule